// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. A host writes the 12-bit converter code either as one full-width word or, on an 8-bit bus, as a right-justified low byte and high nibble in separate writes. The pieces are first staged in a holding rank. A transfer strobe then moves the staged pieces into the output rank, which drives the converter.

Every strobe is active low and only takes effect while the master write strobe is also low. All of them are sampled on the rising clock edge. If a piece's stage enable and the transfer strobe are asserted in the same write, that piece's bus data goes straight into the output rank. The last piece can therefore be loaded and transferred in one write.

An asynchronous active-low clear forces the output rank to the bipolar-zero code 12'h800 and holds it there. The clear never touches the holding rank.

Top module: `dac_dbl_buffer`

## Requirements
- R1: While `clr_n` is low, `dac_code` is 12'h800. The clear takes effect immediately, without waiting for a clock edge.
- R2: At a rising edge where `wr_n` is high, neither rank changes, whatever the other strobes and `bus_data` are.
- R3: At a rising edge with `wr_n` and `lo_ld_n` low, `bus_data[7:0]` is stored in the low staging byte. With `wr_n` and `hi_ld_n` low, `bus_data[11:8]` is stored in the high staging nibble.
- R4: At a rising edge with `wr_n` and `xfer_n` low and both stage enables high, `dac_code` becomes {high nibble, low byte} as staged before that edge. The new value is visible right after that edge.
- R5: When a stage enable and `xfer_n` are low in the same write, the output takes that piece directly from `bus_data`. A piece whose enable is high comes from its staging register.
- R6: While `clr_n` is low, transfers have no effect on `dac_code`. Stage loads still proceed.
- R7: The clear leaves the staging rank unchanged. A transfer after the clear is released restores the code that was staged.
- R8: `dac_code[11]` is the MSB and `dac_code[0]` the LSB. The code passes unchanged in straight or offset binary, including across the 12'h7FF to 12'h800 step.
- R9: An 8-bit host reaches any code with three writes: low byte, then high nibble, then a transfer with both enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the output rank to 12'h800 |
| wr_n | input | 1 | Active-low master write strobe |
| xfer_n | input | 1 | Active-low transfer strobe into the output rank |
| hi_ld_n | input | 1 | Active-low stage enable for bits 11:8 |
| lo_ld_n | input | 1 | Active-low stage enable for bits 7:0 |
| bus_data | input | 12 | Host data, bit 11 MSB |
| dac_code | output | 12 | Registered converter code |

## Verification
A wrong staging value stays hidden at the ports until the next transfer. That transfer then shows the wrong byte or nibble in `dac_code` right after its clock edge, so the bench always follows stage-only writes with a transfer. A wrong pass-through select or wrong write gating appears in `dac_code` one edge after the faulty write. A clear that disturbs the holding rank only shows on the first transfer after release, which the bench checks explicitly.

// File: rtl/dac_if_pkg.sv
// Package: shared widths and constants for the double-buffered DAC register.
// Assumes the code splits into a low byte plus a high remainder.
package dac_if_pkg;
    localparam int CODE_W = 12;
    localparam int LO_W   = 8;
    localparam int HI_W   = CODE_W - LO_W;
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
endpackage

// File: rtl/dac_strobe_decode.sv
// Module: dac_strobe_decode
// Turns the active-low host strobes into active-high enables, each one
// qualified by the master write strobe. Purely combinational.
module dac_strobe_decode (
    input  logic wr_n,
    input  logic xfer_n,
    input  logic hi_ld_n,
    input  logic lo_ld_n,
    output logic lo_load,
    output logic hi_load,
    output logic xfer
);
    // Qualify every enable with the master write strobe.
    always_comb begin
        lo_load = !wr_n && !lo_ld_n;
        hi_load = !wr_n && !hi_ld_n;
        xfer    = !wr_n && !xfer_n;
    end
endmodule

// File: rtl/dac_stage_reg.sv
// Module: dac_stage_reg
// One piece of the holding rank, loaded on a clock edge when enabled.
// It has no reset: its content survives the output clear by design.
module dac_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the bus piece when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end
endmodule

// File: rtl/dac_code_reg.sv
// Module: dac_code_reg
// Output rank. Asynchronous active-low clear to the mid-scale code, which
// overrides the load enable.
module dac_code_reg #(
    parameter int              W   = 12,
    parameter logic [W-1:0]    MID = {1'b1, {(W-1){1'b0}}}
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear to mid-scale at once, otherwise take d on an enabled edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    q <= MID;
        else if (load) q <= d;
    end

    // R1 / R6: the clear holds the output at mid-scale at every edge.
    p_clear_mid_r1: assert property (@(posedge clk) !clr_n |-> q == MID)
        else $error("output not mid-scale during clear");
endmodule

// File: rtl/dac_dbl_buffer.sv
// Module: dac_dbl_buffer (top)
// Double-buffered 12-bit DAC input register: a byte/nibble holding rank,
// a 12-bit output rank, and pass-through from the bus for any piece
// loaded in the same write as the transfer. Assumes synchronous strobes.
module dac_dbl_buffer
    import dac_if_pkg::*;
(
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_n,
    input  logic              xfer_n,
    input  logic              hi_ld_n,
    input  logic              lo_ld_n,
    input  logic [CODE_W-1:0] bus_data,
    output logic [CODE_W-1:0] dac_code
);
    logic              lo_load, hi_load, xfer;
    logic [LO_W-1:0]   lo_q, lo_next;
    logic [HI_W-1:0]   hi_q, hi_next;

    dac_strobe_decode u_dec (
        .wr_n    (wr_n),
        .xfer_n  (xfer_n),
        .hi_ld_n (hi_ld_n),
        .lo_ld_n (lo_ld_n),
        .lo_load (lo_load),
        .hi_load (hi_load),
        .xfer    (xfer)
    );

    dac_stage_reg #(.W(LO_W)) u_lo (
        .clk (clk), .load (lo_load), .d (bus_data[LO_W-1:0]), .q (lo_q)
    );

    dac_stage_reg #(.W(HI_W)) u_hi (
        .clk (clk), .load (hi_load), .d (bus_data[CODE_W-1:LO_W]), .q (hi_q)
    );

    // Pick bus data for a piece loaded this write, else its staged copy.
    always_comb begin
        lo_next = lo_load ? bus_data[LO_W-1:0]      : lo_q;
        hi_next = hi_load ? bus_data[CODE_W-1:LO_W] : hi_q;
    end

    dac_code_reg #(.W(CODE_W), .MID(MID_CODE)) u_out (
        .clk   (clk),
        .clr_n (clr_n),
        .load  (xfer),
        .d     ({hi_next, lo_next}),
        .q     (dac_code)
    );

    // R2: without the write strobe neither rank moves.
    p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
        wr_n |=> ($stable(dac_code) && $stable(lo_q) && $stable(hi_q)))
        else $error("state changed with write strobe high");

    // R3: a staged byte equals the bus byte of the loading write.
    p_lo_stage_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (!wr_n && !lo_ld_n) |=> lo_q == $past(bus_data[LO_W-1:0]))
        else $error("low byte not staged");

    // R4: a plain transfer copies the previously staged pieces.
    p_xfer_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (!wr_n && !xfer_n && hi_ld_n && lo_ld_n) |=> dac_code == $past({hi_q, lo_q}))
        else $error("transfer did not copy staged code");

    // R5: a high nibble loaded with the transfer reaches the output directly.
    p_hi_through_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (!wr_n && !xfer_n && !hi_ld_n) |=> dac_code[CODE_W-1:LO_W] == $past(bus_data[CODE_W-1:LO_W]))
        else $error("high nibble not passed through");
endmodule

// File: tb/tb_dac_dbl_buffer.sv
module tb_dac_dbl_buffer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr_n;
        logic        xfer_n;
        logic        hi_n;
        logic        lo_n;
        logic [11:0] din;
        logic [11:0] expect_code;
    } vec_t;

    // Rows walk the main function; expected codes are worked out by hand.
    localparam vec_t TBL [11] = '{
        '{1'b0,1'b0,1'b0,1'b0,12'hABC,12'hABC}, // R5 full-width single write
        '{1'b0,1'b1,1'b1,1'b0,12'h012,12'hABC}, // R3 R9 stage low byte 12
        '{1'b0,1'b1,1'b0,1'b1,12'h300,12'hABC}, // R3 R9 stage high nibble 3
        '{1'b0,1'b0,1'b1,1'b1,12'hFFF,12'h312}, // R4 R9 plain transfer
        '{1'b1,1'b0,1'b0,1'b0,12'h7FF,12'h312}, // R2 write strobe high
        '{1'b0,1'b0,1'b1,1'b0,12'h0FF,12'h3FF}, // R5 low byte through
        '{1'b0,1'b0,1'b0,1'b1,12'h7AA,12'h7FF}, // R5 R8 high nibble through
        '{1'b0,1'b0,1'b0,1'b0,12'h800,12'h800}, // R8 major carry step
        '{1'b1,1'b1,1'b1,1'b1,12'h555,12'h800}, // R2 idle
        '{1'b0,1'b1,1'b0,1'b0,12'h123,12'h800}, // R3 stage both pieces
        '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h123}  // R4 transfer staged
    };

    logic        clk = 1'b0;
    logic        clr_n = 1'b1;
    logic        wr_n = 1'b1, xfer_n = 1'b1, hi_ld_n = 1'b1, lo_ld_n = 1'b1;
    logic [11:0] bus_data = '0;
    logic [11:0] dac_code;
    int          n_checks = 0;
    int          n_fail = 0;

    dac_dbl_buffer dut (
        .clk (clk), .clr_n (clr_n), .wr_n (wr_n), .xfer_n (xfer_n),
        .hi_ld_n (hi_ld_n), .lo_ld_n (lo_ld_n),
        .bus_data (bus_data), .dac_code (dac_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dac_code=%h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the rising edge captures; sample at the next falling edge.
    task automatic do_write(input logic w, input logic x, input logic h, input logic l,
                            input logic [11:0] d);
        @(negedge clk);
        wr_n = w; xfer_n = x; hi_ld_n = h; lo_ld_n = l; bus_data = d;
        @(negedge clk);
        wr_n = 1'b1; xfer_n = 1'b1; hi_ld_n = 1'b1; lo_ld_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1 clr_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset state", dac_code, 12'h800);
        clr_n = 1'b1;

        for (int i = 0; i < 11; i++) begin
            do_write(TBL[i].wr_n, TBL[i].xfer_n, TBL[i].hi_n, TBL[i].lo_n, TBL[i].din);
            check($sformatf("table row %0d (R2 R3 R4 R5 R8 R9)", i), dac_code, TBL[i].expect_code);
        end

        // R1: the clear acts between edges, without a clock.
        @(posedge clk); #1 clr_n = 1'b0; #1;
        check("R1 asynchronous clear", dac_code, 12'h800);

        // R6: a load-and-transfer during the clear leaves the output at mid-scale.
        do_write(1'b0, 1'b0, 1'b0, 1'b0, 12'h456);
        check("R6 transfer blocked by clear", dac_code, 12'h800);
        @(negedge clk); clr_n = 1'b1;
        check("R6 released, still mid-scale", dac_code, 12'h800);
        do_write(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        check("R6 stage load during clear kept", dac_code, 12'h456);

        // R7: a clear alone leaves the staged code in place.
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        check("R7 clear applied", dac_code, 12'h800);
        do_write(1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF);
        check("R7 staged code restored", dac_code, 12'h456);

        // R2: each stage enable without the write strobe is ignored.
        do_write(1'b1, 1'b1, 1'b1, 1'b0, 12'h0AB);
        do_write(1'b1, 1'b1, 1'b0, 1'b1, 12'hC00);
        do_write(1'b0, 1'b0, 1'b1, 1'b1, 12'h000);
        check("R2 ungated stage enables ignored", dac_code, 12'h456);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule